// File: doc/BRIEF.md
# Two-Channel Pulse-Width Modulator

This block drives two pulse-width modulated output pins, channel A and channel B, from a small word-addressed register bus. Software programs, per channel, a period length (RANGE) and an active-clock count (DATA), then turns the channel on through one shared control word. Each channel runs one of two algorithms. Mark/space mode holds the pin active for the first DATA ticks of every RANGE-tick period. Distributed mode gives the same number of active ticks per period, but spreads them as evenly as it can across the period.

Both channels advance on one shared PWM tick, `pwm_tick`, which is a clock enable from a divider outside the block. Each channel has its own polarity bit, which inverts the pin. Each also has a silence bit, which sets the pin level while the channel is off.

A new RANGE or DATA value is held back until the channel's next period boundary. This keeps the pulse already in progress intact.

Top module: `duo_pwm`

## Requirements
- R1: After reset the control word reads 0, both RANGE registers read 32, both DATA registers read 0, and both output pins are low.
- R2: Register word addresses are 0 for control, 4 and 5 for channel A RANGE and DATA, and 8 and 9 for channel B RANGE and DATA. These are byte offsets 0x00, 0x10, 0x14, 0x20 and 0x24. Per channel, only the enable bit (0), silence bit (3), polarity bit (4) and mark/space bit (7) are kept. All other control bits, including the FIFO-clear bit 6 and bit 14, read 0. Unmapped addresses read 0.
- R3: With the mark/space bit at 1, the raw level at period position p (0 to RANGE-1, one position per tick) is active when p < DATA.
- R4: With the mark/space bit at 0, the raw level at position p is active when floor((p+1)·DATA/RANGE) > floor(p·DATA/RANGE). This gives exactly DATA active ticks per period, spread evenly.
- R5: When DATA ≥ RANGE, the raw level is active at every position in either mode.
- R6: The pin equals the raw level XOR the polarity bit. A polarity change shows on the pin in the clock after the write, without waiting for a tick.
- R7: While a channel's enable bit is 0, its raw level becomes the silence bit one clock later and its period counter returns to position 0. After an enabling write, the first position-0 level appears one clock after the write.
- R8: RANGE and DATA are sampled only when the channel is at position 0. A write made in mid-period takes effect from the next period.
- R9: Channel B's control fields are channel A's shifted up by 8 bits. The two channels count and decode independently. Writing 0x81 turns on channel A in mark/space mode, and writing 0x8100 turns on channel B in mark/space mode.
- R10: An enabled channel changes position and raw level only on clock edges where `pwm_tick` is high. On other edges its pin holds, apart from polarity changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_tick | input | 1 | Shared PWM tick (clock enable) for both channels |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from the address |
| pwm_out | output | 2 | Output pins; bit 0 is channel A, bit 1 is channel B |

## Verification
Assertions check the following on every cycle:
- A disabled channel's pin follows its silence and polarity bits.
- A channel's pin holds when the tick is low, except for a polarity change.
- Control writes are masked to the kept bits.
- Reserved and unmapped reads return 0.

The actual waveforms come only from the bench scenarios, which compare the pins tick by tick against sequences computed from the formulas above. These waveforms cover:
- the mark/space and distributed patterns;
- the full-on case;
- the counter restart after a disable;
- the deferral of a mid-period DATA write;
- both channels running at once in different modes.

// File: rtl/duo_pwm_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the two-channel PWM.
// Assumes exactly two channels packed into one 16-bit control word.
package duo_pwm_pkg;
    localparam int NUM_CH       = 2;
    localparam int CH_STRIDE    = 8;   // control bits per channel
    localparam int B_EN         = 0;
    localparam int B_SIL        = 3;
    localparam int B_POL        = 4;
    localparam int B_MS         = 7;
    localparam int WA_CTL       = 0;   // word addresses
    localparam int WA_CH_BASE   = 4;
    localparam int WA_CH_STRIDE = 4;
    localparam int WA_RNG_OFS   = 0;
    localparam int WA_DAT_OFS   = 1;

    typedef struct packed {
        logic ms;   // 1 = mark/space, 0 = distributed
        logic pol;  // invert output
        logic sil;  // raw level while disabled
        logic en;   // channel enable
    } chan_cfg_t;
endpackage

// File: rtl/duo_pwm_regs.sv
`timescale 1ns/1ps
// Register file: control word plus RANGE/DATA per channel.
// Assumes single-cycle writes (bus_sel && bus_wr) and a combinational read.
module duo_pwm_regs
    import duo_pwm_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int RNG_RST = 32,
    parameter int DAT_RST = 0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_sel,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    output chan_cfg_t [NUM_CH-1:0]           cfg_o,
    output logic [NUM_CH-1:0][DATA_W-1:0]    rng_o,
    output logic [NUM_CH-1:0][DATA_W-1:0]    dat_o
);
    chan_cfg_t [NUM_CH-1:0]        cfg_q;
    logic [NUM_CH-1:0][DATA_W-1:0] rng_q;
    logic [NUM_CH-1:0][DATA_W-1:0] dat_q;
    logic                          wr_en;

    assign wr_en = bus_sel && bus_wr;

    function automatic logic [ADDR_W-1:0] rng_wa(input int c);
        return ADDR_W'(WA_CH_BASE + WA_CH_STRIDE * c + WA_RNG_OFS);
    endfunction

    function automatic logic [ADDR_W-1:0] dat_wa(input int c);
        return ADDR_W'(WA_CH_BASE + WA_CH_STRIDE * c + WA_DAT_OFS);
    endfunction

    // Register writes; only the in-scope control bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                cfg_q[c] <= '0;
                rng_q[c] <= DATA_W'(RNG_RST);
                dat_q[c] <= DATA_W'(DAT_RST);
            end
        end else if (wr_en) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (bus_addr == ADDR_W'(WA_CTL)) begin
                    cfg_q[c].en  <= bus_wdata[CH_STRIDE * c + B_EN];
                    cfg_q[c].sil <= bus_wdata[CH_STRIDE * c + B_SIL];
                    cfg_q[c].pol <= bus_wdata[CH_STRIDE * c + B_POL];
                    cfg_q[c].ms  <= bus_wdata[CH_STRIDE * c + B_MS];
                end
                if (bus_addr == rng_wa(c)) rng_q[c] <= bus_wdata;
                if (bus_addr == dat_wa(c)) dat_q[c] <= bus_wdata;
            end
        end
    end

    // Read mux; unstored and unmapped bits return zero.
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(WA_CTL)) begin
                bus_rdata[CH_STRIDE * c + B_EN]  = cfg_q[c].en;
                bus_rdata[CH_STRIDE * c + B_SIL] = cfg_q[c].sil;
                bus_rdata[CH_STRIDE * c + B_POL] = cfg_q[c].pol;
                bus_rdata[CH_STRIDE * c + B_MS]  = cfg_q[c].ms;
            end
            if (bus_addr == rng_wa(c)) bus_rdata = rng_q[c];
            if (bus_addr == dat_wa(c)) bus_rdata = dat_q[c];
        end
    end

    assign cfg_o = cfg_q;
    assign rng_o = rng_q;
    assign dat_o = dat_q;
endmodule

// File: rtl/duo_pwm_chan.sv
`timescale 1ns/1ps
// One PWM channel: period counter, mark/space and distributed level logic.
// Assumes tick_i is a one-clock enable; RANGE/DATA are latched at position 0.
module duo_pwm_chan
    import duo_pwm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  chan_cfg_t         cfg_i,
    input  logic [DATA_W-1:0] rng_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic              out_o
);
    localparam int ACC_W = DATA_W + 1;

    logic [DATA_W-1:0] pos_q, rng_lat, dat_lat;
    logic [ACC_W-1:0]  acc_q;
    logic              lvl_q;

    logic              at_start, full, wrap, hit, ms_act, dist_act, act;
    logic [DATA_W-1:0] rng_e, dat_e, pos_nxt;
    logic [ACC_W-1:0]  acc_e, sum, acc_nxt;

    // Effective settings: fresh values at position 0, latched ones otherwise.
    always_comb begin
        at_start = (pos_q == '0);
        rng_e    = at_start ? rng_i : rng_lat;
        dat_e    = at_start ? dat_i : dat_lat;
        acc_e    = at_start ? '0 : acc_q;
        full     = (dat_e >= rng_e);
    end

    // Next period position and both level algorithms.
    always_comb begin
        wrap     = ({1'b0, pos_q} + ACC_W'(1)) >= {1'b0, rng_e};
        pos_nxt  = wrap ? '0 : pos_q + DATA_W'(1);
        ms_act   = full || (pos_q < dat_e);
        sum      = acc_e + {1'b0, dat_e};
        hit      = (sum >= {1'b0, rng_e});
        dist_act = full || hit;
        if (full)     acc_nxt = '0;
        else if (hit) acc_nxt = sum - {1'b0, rng_e};
        else          acc_nxt = sum;
        act      = cfg_i.ms ? ms_act : dist_act;
    end

    // Channel state: idle while disabled, advance on ticks while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            acc_q   <= '0;
            rng_lat <= '0;
            dat_lat <= '0;
            lvl_q   <= 1'b0;
        end else if (!cfg_i.en) begin
            pos_q <= '0;
            acc_q <= '0;
            lvl_q <= cfg_i.sil;
        end else if (tick_i) begin
            pos_q <= pos_nxt;
            acc_q <= acc_nxt;
            lvl_q <= act;
            if (at_start) begin
                rng_lat <= rng_i;
                dat_lat <= dat_i;
            end
        end
    end

    assign out_o = lvl_q ^ cfg_i.pol;
endmodule

// File: rtl/duo_pwm.sv
`timescale 1ns/1ps
// Top level: register file feeding two identical PWM channels.
// Assumes both channels share clk and the pwm_tick enable.
module duo_pwm
    import duo_pwm_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int RNG_RST = 32,
    parameter int DAT_RST = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    chan_cfg_t [NUM_CH-1:0]        cfg_w;
    logic [NUM_CH-1:0][DATA_W-1:0] rng_w;
    logic [NUM_CH-1:0][DATA_W-1:0] dat_w;

    duo_pwm_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RNG_RST(RNG_RST),
        .DAT_RST(DAT_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cfg_o    (cfg_w),
        .rng_o    (rng_w),
        .dat_o    (dat_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        duo_pwm_chan #(.DATA_W(DATA_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .tick_i(pwm_tick),
            .cfg_i (cfg_w[g]),
            .rng_i (rng_w[g]),
            .dat_i (dat_w[g]),
            .out_o (pwm_out[g])
        );
    end
endmodule

// File: rtl/duo_pwm_chk.sv
`timescale 1ns/1ps
// Assertion checker for duo_pwm, bound to every instance.
// Assumes it observes the top's ports and the decoded channel settings.
module duo_pwm_chk
    import duo_pwm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwm_tick,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic [DATA_W-1:0]      bus_rdata,
    input  logic [NUM_CH-1:0]      pwm_out,
    input  chan_cfg_t [NUM_CH-1:0] cfg
);
    logic [DATA_W-1:0] ctl_img, ctl_mask;
    logic              addr_known;

    // Rebuild the control word image and the set of mapped addresses.
    always_comb begin
        ctl_img    = '0;
        ctl_mask   = '0;
        addr_known = (bus_addr == ADDR_W'(WA_CTL));
        for (int c = 0; c < NUM_CH; c++) begin
            ctl_img[CH_STRIDE * c + B_EN]   = cfg[c].en;
            ctl_img[CH_STRIDE * c + B_SIL]  = cfg[c].sil;
            ctl_img[CH_STRIDE * c + B_POL]  = cfg[c].pol;
            ctl_img[CH_STRIDE * c + B_MS]   = cfg[c].ms;
            ctl_mask[CH_STRIDE * c + B_EN]  = 1'b1;
            ctl_mask[CH_STRIDE * c + B_SIL] = 1'b1;
            ctl_mask[CH_STRIDE * c + B_POL] = 1'b1;
            ctl_mask[CH_STRIDE * c + B_MS]  = 1'b1;
            if (bus_addr == ADDR_W'(WA_CH_BASE + WA_CH_STRIDE * c + WA_RNG_OFS)) addr_known = 1'b1;
            if (bus_addr == ADDR_W'(WA_CH_BASE + WA_CH_STRIDE * c + WA_DAT_OFS)) addr_known = 1'b1;
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(WA_CTL)) |-> (bus_rdata[6] == 1'b0 && bus_rdata[14] == 1'b0)); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !addr_known) |-> (bus_rdata == '0)); // R2

    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(WA_CTL)) |=> (ctl_img == ($past(bus_wdata) & ctl_mask))); // R9

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg[c].en |=> (pwm_out[c] == ($past(cfg[c].sil) ^ cfg[c].pol))); // R7

        AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[c].en && !pwm_tick) |=> (pwm_out[c] == ($past(pwm_out[c]) ^ $past(cfg[c].pol) ^ cfg[c].pol))); // R10
    end
endmodule

bind duo_pwm duo_pwm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_tick (pwm_tick),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pwm_out  (pwm_out),
    .cfg      (cfg_w)
);

// File: tb/duo_pwm_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected pin levels, monitor compares.
module duo_pwm_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_tick = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [1:0] exp;
        logic [1:0] mask;
        string      tag;
    } item_t;
    item_t q[$];

    always #2.5 clk = ~clk;

    duo_pwm u_duo_pwm (
        .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: one queued expectation per falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.mask != 2'b00) begin
                checks++;
                if ((pwm_out & it.mask) !== (it.exp & it.mask)) begin
                    errors++;
                    $display("FAIL %s: pwm_out=%b expected=%b mask=%b", it.tag, pwm_out, it.exp, it.mask);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    task automatic push(input logic [1:0] e, input logic [1:0] m, input string t);
        item_t it;
        it.exp = e; it.mask = m; it.tag = t;
        q.push_back(it);
    endtask

    // Expected raw level from the requirement formulas (R3, R4, R5).
    function automatic logic exp_act(input bit ms, input int r, input int d, input int p);
        if (d >= r) return 1'b1;
        if (ms) return (p < d);
        return ((p + 1) * d) / r > (p * d) / r;
    endfunction

    task automatic bus_write(input int wa, input logic [31:0] v);
        bus_sel = 1; bus_wr = 1; bus_addr = 4'(wa); bus_wdata = v;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic check_reg(input int wa, input logic [31:0] exp, input string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = 4'(wa);
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s: addr %0d read=%h expected=%h", tag, wa, bus_rdata, exp);
        end
        bus_sel = 0;
    endtask

    task automatic drain();
        do @(posedge clk); while (q.size() != 0);
        #1;
    endtask

    // Program one channel, enable it, and expect n positions from position 0.
    task automatic run_chan(input int ch, input bit ms, input bit pol, input int r, input int d,
                            input int n, input string tag);
        logic [1:0] m;
        m = 2'(1 << ch);
        bus_write(4 + 4 * ch, r);
        bus_write(5 + 4 * ch, d);
        bus_write(0, (32'h1 | (32'(ms) << 7) | (32'(pol) << 4)) << (8 * ch));
        push(pol ? m : 2'b00, m, tag);
        for (int i = 0; i < n; i++)
            push((exp_act(ms, r, d, i % r) ^ pol) ? m : 2'b00, m, tag);
        drain();
        bus_write(0, 0);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        check_reg(0, 32'h0, "R1");
        check_reg(4, 32'd32, "R1");
        check_reg(5, 32'd0, "R1");
        check_reg(8, 32'd32, "R1");
        check_reg(9, 32'd0, "R1");
        checks++;
        if (pwm_out !== 2'b00) begin
            errors++;
            $display("FAIL R1: pwm_out=%b expected=00", pwm_out);
        end

        // R2: map, kept control bits, unmapped reads
        bus_write(0, 32'hFFFF);
        check_reg(0, 32'h9999, "R2");
        bus_write(0, 32'h0);
        bus_write(8, 32'h1234_5678);
        check_reg(8, 32'h1234_5678, "R2");
        check_reg(4, 32'd32, "R2");
        check_reg(1, 32'h0, "R2");
        check_reg(6, 32'h0, "R2");
        @(posedge clk); #1;

        // R3: mark/space patterns
        run_chan(0, 1, 0, 5, 2, 10, "R3");
        run_chan(0, 1, 0, 4, 0, 4, "R3");
        // R4: distributed patterns on both channels
        run_chan(0, 0, 0, 5, 2, 10, "R4");
        run_chan(1, 0, 0, 7, 3, 14, "R4");
        // R5: DATA at or above RANGE
        run_chan(0, 1, 0, 4, 4, 8, "R5");
        run_chan(1, 0, 0, 3, 9, 6, "R5");
        // R6: inverted polarity
        run_chan(0, 1, 1, 4, 1, 8, "R6");
        // R7: restart at position 0 after a mid-period disable
        run_chan(0, 1, 0, 6, 3, 4, "R7");
        run_chan(0, 1, 0, 6, 3, 12, "R7");

        // R7 and R6: idle level follows silence then polarity
        bus_write(0, 32'h08);
        push(2'b00, 2'b01, "R7");
        repeat (3) push(2'b01, 2'b01, "R7");
        drain();
        bus_write(0, 32'h18);
        repeat (3) push(2'b00, 2'b01, "R6");
        drain();
        bus_write(0, 32'h00);
        push(2'b01, 2'b01, "R7");
        repeat (2) push(2'b00, 2'b01, "R7");
        drain();

        // R8: DATA write in mid-period waits for the boundary
        bus_write(4, 8);
        bus_write(5, 2);
        bus_write(0, 32'h81);
        push(2'b00, 2'b01, "R8");
        for (int i = 0; i < 8; i++) push(exp_act(1, 8, 2, i) ? 2'b01 : 2'b00, 2'b01, "R8");
        for (int i = 0; i < 8; i++) push(exp_act(1, 8, 6, i) ? 2'b01 : 2'b00, 2'b01, "R8");
        repeat (2) @(posedge clk);
        #1;
        bus_write(5, 6);
        drain();
        bus_write(0, 0);
        @(posedge clk); #1;

        // R9: both channels at once, A mark/space, B distributed
        bus_write(4, 4); bus_write(5, 1);
        bus_write(8, 4); bus_write(9, 3);
        bus_write(0, 32'h0181);
        push(2'b00, 2'b11, "R9");
        for (int i = 0; i < 8; i++)
            push({exp_act(0, 4, 3, i % 4), exp_act(1, 4, 1, i % 4)}, 2'b11, "R9");
        drain();
        bus_write(0, 0);
        @(posedge clk); #1;

        // R10: tick low on two edges freezes position 1
        bus_write(4, 4); bus_write(5, 3);
        bus_write(0, 32'h81);
        push(2'b00, 2'b01, "R10");
        push(2'b01, 2'b01, "R10");  // pos 0
        push(2'b01, 2'b01, "R10");  // pos 1
        push(2'b01, 2'b01, "R10");  // held
        push(2'b01, 2'b01, "R10");  // held
        push(2'b01, 2'b01, "R10");  // pos 2
        push(2'b00, 2'b01, "R10");  // pos 3
        push(2'b01, 2'b01, "R10");  // pos 0
        repeat (2) @(posedge clk);
        #1 pwm_tick = 1'b0;
        repeat (2) @(posedge clk);
        #1 pwm_tick = 1'b1;
        drain();
        bus_write(0, 0);

        finish_run();
    end
endmodule